// File: doc/BRIEF.md
# Double-Precision Significand Multiply, Normalize and Round Unit

This block is the significand datapath of a double-precision floating-point multiplier. It receives the two 52-bit stored fraction fields, puts back the hidden leading one on each, and multiplies the two 53-bit significands. The 106-bit product is then normalized to 53 bits and rounded to nearest, with ties going to even.

It returns the 52-bit result fraction together with three side signals. Two of these signals tell a separate exponent path when to add one to the exponent: one for the normalizing right shift, and one for a rounding carry out of the significand. The third is an inexact flag for the special-case output logic.

The block does not handle signs, exponents, special operands or format conversion. A parameter selects between a purely combinational path and a single output register stage with a valid bit.

Top module: `sig_mul_round`

## Requirements
- R1: The hidden one is restored on both operands. With the default register stage, an accepted input pair produces its result on `res_frac` exactly one clock later. The value is the rounded 52-bit fraction below the leading one of the normalized product.
- R2: When product bit 105 is set, the kept significand is bits 105:53 and `exp_inc_norm` is 1. Otherwise the kept significand is bits 104:52 and `exp_inc_norm` is 0.
- R3: Rounding is to nearest. A discarded part above one half of the kept LSB rounds the significand up. A discarded part below one half truncates.
- R4: A discarded part of exactly one half rounds up when the kept LSB is 1 and truncates when it is 0 (ties to even).
- R5: When rounding carries out of the 53-bit significand, `res_frac` is all zeros and `exp_inc_round` is 1. In every other case `exp_inc_round` is 0.
- R6: `inexact` is 1 exactly when some discarded product bit is nonzero. This is the OR of the guard bit, the round bit and the sticky bit.
- R7: `out_valid` equals `in_valid` of the previous clock. Back-to-back inputs produce back-to-back results.
- R8: An active-low reset (`rst_n` = 0) clears `out_valid` and the registered result fields.
- R9: A cycle with `in_valid` = 0 leaves the registered result fields unchanged, whatever is on `frac_a` and `frac_b`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| frac_a | input | 52 | Stored fraction of operand A |
| frac_b | input | 52 | Stored fraction of operand B |
| out_valid | output | 1 | Result present |
| res_frac | output | 52 | Rounded result fraction |
| exp_inc_norm | output | 1 | Add one to the exponent for the normalizing shift |
| exp_inc_round | output | 1 | Add one to the exponent for a rounding carry-out |
| inexact | output | 1 | Discarded product bits were nonzero |

## Verification
The bench targets products on both sides of the normalization boundary. A design that chose the wrong shift would return a fraction scaled by two and a wrong `exp_inc_norm`.

It drives exact halfway cases with both odd and even kept LSBs, where a design that always rounded half up, or truncated, would miss by one ULP. It also drives the single pattern family that carries out of the significand (1.111…10 × 1.000…01). There, a design that dropped the carry would wrap the fraction to the wrong value or leave `exp_inc_round` low.

Idle cycles carrying garbage operands, streaming inputs and a mid-stream reset expose capture and valid-timing faults. A stream of pseudo-random pairs is compared against an integer-remainder rounding model.

// File: rtl/sig_mul_round.sv
module sig_mul_round #(
  parameter int FRAC_W = 52,
  parameter bit PIPE   = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [FRAC_W-1:0] frac_a,
  input  logic [FRAC_W-1:0] frac_b,
  output logic              out_valid,
  output logic [FRAC_W-1:0] res_frac,
  output logic              exp_inc_norm,
  output logic              exp_inc_round,
  output logic              inexact
);
  localparam int SIG_W  = FRAC_W + 1;
  localparam int PROD_W = 2 * SIG_W;

  logic [PROD_W-1:0] prod, norm;
  logic [SIG_W-1:0]  kept;
  logic [SIG_W:0]    summed;
  logic              top, g_bit, r_bit, s_bit, bump;
  logic [FRAC_W-1:0] c_frac;
  logic              c_ovf, c_inx;

  assign prod = {{SIG_W{1'b0}}, 1'b1, frac_a} * {{SIG_W{1'b0}}, 1'b1, frac_b};
  assign top  = prod[PROD_W-1];
  assign norm = top ? prod : {prod[PROD_W-2:0], 1'b0};

  assign kept  = norm[PROD_W-1:SIG_W];
  assign g_bit = norm[SIG_W-1];
  assign r_bit = norm[SIG_W-2];
  assign s_bit = |norm[SIG_W-3:0];

  assign bump   = g_bit & (r_bit | s_bit | kept[0]);
  assign summed = {1'b0, kept} + {{SIG_W{1'b0}}, bump};
  assign c_ovf  = summed[SIG_W];
  assign c_frac = c_ovf ? '0 : summed[FRAC_W-1:0];
  assign c_inx  = g_bit | r_bit | s_bit;

  generate
    if (PIPE) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          out_valid     <= 1'b0;
          res_frac      <= '0;
          exp_inc_norm  <= 1'b0;
          exp_inc_round <= 1'b0;
          inexact       <= 1'b0;
        end else begin
          out_valid <= in_valid;
          if (in_valid) begin
            res_frac      <= c_frac;
            exp_inc_norm  <= top;
            exp_inc_round <= c_ovf;
            inexact       <= c_inx;
          end
        end
      end

      p_valid_follows_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(in_valid));
      p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> ($stable(res_frac) && $stable(exp_inc_round) && $stable(inexact)));
    end else begin : g_comb
      assign out_valid     = in_valid;
      assign res_frac      = c_frac;
      assign exp_inc_norm  = top;
      assign exp_inc_round = c_ovf;
      assign inexact       = c_inx;
    end
  endgenerate

  // A carry-out of rounding forces the fraction to zero (R5).
  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && exp_inc_round) |-> (res_frac == '0));
  // Rounding can only carry out of a product below two, so both increments never coincide (R2, R5).
  p_incs_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(exp_inc_round && exp_inc_norm));
  // A carry-out needs a round-up, which needs discarded bits (R6).
  p_ovf_needs_inexact_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && exp_inc_round) |-> inexact);
  // Rounding up the normalized significand cannot leave a nonzero fraction if the input pair was 1.0 x 1.0 (R1).
  p_unit_exact_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (PIPE && $past(in_valid) && $past(frac_a) == '0 && $past(frac_b) == '0)
      |-> (res_frac == '0 && !inexact && !exp_inc_norm));
endmodule

// File: tb/sig_mul_round_tb.sv
module sig_mul_round_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [51:0] frac_a = '0, frac_b = '0;
  logic        out_valid, exp_inc_norm, exp_inc_round, inexact;
  logic [51:0] res_frac;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  sig_mul_round u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .frac_a(frac_a), .frac_b(frac_b),
    .out_valid(out_valid), .res_frac(res_frac), .exp_inc_norm(exp_inc_norm),
    .exp_inc_round(exp_inc_round), .inexact(inexact)
  );

  // {frac[51:0], norm_inc, round_ovf, inexact}
  function automatic logic [54:0] model(input logic [51:0] a, input logic [51:0] b);
    logic [105:0] p, rem, half;
    logic [53:0]  q;
    int k;
    logic up;
    p    = {53'd0, 1'b1, a} * {53'd0, 1'b1, b};
    k    = p[105] ? 53 : 52;
    q    = 54'(p >> k);
    rem  = p & ((106'd1 << k) - 106'd1);
    half = 106'd1 << (k - 1);
    up   = (rem > half) || (rem == half && q[0]);
    q    = q + 54'(up);
    if (q[53]) return {52'd0, p[105], 1'b1, rem != 0};
    return {q[51:0], p[105], 1'b0, rem != 0};
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(input string req, input logic [51:0] a, input logic [51:0] b);
    logic [54:0] e;
    e = model(a, b);
    frac_a = a; frac_b = b; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid"}, 64'(out_valid), 64'd1);
    check({req, " result"}, 64'({res_frac, exp_inc_norm, exp_inc_round, inexact}), 64'(e));
  endtask

  task automatic t_reset_r8;
    check("R8 reset valid", 64'(out_valid), 64'd0);
    check("R8 reset data", 64'({res_frac, exp_inc_norm, exp_inc_round, inexact}), 64'd0);
  endtask

  task automatic t_unit_r1;
    run_op("R1 one by one", 52'd0, 52'd0);
    check("R1 exact flags", 64'({exp_inc_norm, exp_inc_round, inexact}), 64'd0);
  endtask

  task automatic t_norm_r2;
    run_op("R2 1.5x1.5", 52'h8_0000_0000_0000, 52'h8_0000_0000_0000);
    check("R2 norm inc", 64'({exp_inc_norm, res_frac}), 64'({1'b1, 52'h2_0000_0000_0000}));
    run_op("R2 max x max", '1, '1);
    check("R2 max norm", 64'(exp_inc_norm), 64'd1);
  endtask

  task automatic t_round_r3;
    run_op("R3 mixed pair", 52'h1_2345_6789_ABCD, 52'hF_EDCB_A987_6543);
    // 1.0...01 squared: remainder one LSB of product, far below half, truncates
    run_op("R3 below half", 52'd1, 52'd1);
    check("R3 truncate", 64'(res_frac), 64'd2);
  endtask

  task automatic t_tie_r4;
    // (1+2^-52)*1.5: tie with odd kept LSB -> up
    run_op("R4 tie odd", 52'd1, 52'h8_0000_0000_0000);
    check("R4 tie odd up", 64'({res_frac, inexact}), 64'({52'h8_0000_0000_0002, 1'b1}));
    // (1+3*2^-52)*1.5: tie with even kept LSB -> stays
    run_op("R4 tie even", 52'd3, 52'h8_0000_0000_0000);
    check("R4 tie even hold", 64'({res_frac, inexact}), 64'({52'h8_0000_0000_0004, 1'b1}));
  endtask

  task automatic t_ovf_r5;
    run_op("R5 carry out", 52'hF_FFFF_FFFF_FFFE, 52'd1);
    check("R5 flags", 64'({res_frac, exp_inc_norm, exp_inc_round, inexact}), 64'({52'd0, 3'b011}));
  endtask

  task automatic t_inexact_r6;
    run_op("R6 exact 1.5x1.25", 52'h8_0000_0000_0000, 52'h4_0000_0000_0000);
    check("R6 exact", 64'(inexact), 64'd0);
  endtask

  task automatic t_stream_r7;
    logic [54:0] e1, e2;
    e1 = model(52'h0_0F0F_0F0F_0F0F, 52'h3_3333_3333_3333);
    e2 = model(52'hA_AAAA_AAAA_AAAA, 52'h5_5555_5555_5555);
    check("R7 idle before", 64'(out_valid), 64'd0);
    frac_a = 52'h0_0F0F_0F0F_0F0F; frac_b = 52'h3_3333_3333_3333; in_valid = 1'b1;
    @(negedge clk);
    check("R7 first valid", 64'(out_valid), 64'd1);
    check("R7 first data", 64'({res_frac, exp_inc_norm, exp_inc_round, inexact}), 64'(e1));
    frac_a = 52'hA_AAAA_AAAA_AAAA; frac_b = 52'h5_5555_5555_5555;
    @(negedge clk);
    in_valid = 1'b0;
    check("R7 second data", 64'({res_frac, exp_inc_norm, exp_inc_round, inexact}), 64'(e2));
    @(negedge clk);
    check("R7 valid drops", 64'(out_valid), 64'd0);
  endtask

  task automatic t_hold_r9;
    logic [54:0] e;
    run_op("R9 setup", 52'h7_1234_0000_00FF, 52'h0_00AB_CDEF_0001);
    e = model(52'h7_1234_0000_00FF, 52'h0_00AB_CDEF_0001);
    frac_a = '1; frac_b = 52'h5_0505_0505_0505;
    repeat (3) @(negedge clk);
    check("R9 held", 64'({res_frac, exp_inc_norm, exp_inc_round, inexact}), 64'(e));
  endtask

  task automatic t_random;
    logic [63:0] s = 64'h2545_F491_4F6C_DD1D;
    for (int i = 0; i < 200; i++) begin
      logic [51:0] a, b;
      s = s * 64'd6364136223846793005 + 64'd1442695040888963407;
      a = s[63:12];
      s = s * 64'd6364136223846793005 + 64'd1442695040888963407;
      b = s[63:12];
      run_op("R3 R6 random", a, b);
    end
  endtask

  task automatic t_midreset_r8;
    frac_a = 52'h1; frac_b = 52'h2; in_valid = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 mid reset valid", 64'(out_valid), 64'd0);
    check("R8 mid reset data", 64'(res_frac), 64'd0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r8();
    rst_n = 1'b1;
    @(negedge clk);
    t_stream_r7();
    t_unit_r1();
    t_norm_r2();
    t_round_r3();
    t_tie_r4();
    t_ovf_r5();
    t_inexact_r6();
    t_hold_r9();
    t_random();
    t_midreset_r8();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule